// File: doc/BRIEF.md
# Write-Only Volatile Key Register with Validity Flag

This block holds a 512-bit secret key that is loaded serially through a JTAG test port and is never read back. It sits next to a TAP controller and takes from it the current instruction and the Shift-DR, Update-DR and Run-Test/Idle state indications. When the key-load instruction is current, each Shift-DR cycle moves one TDI bit into a staging chain. At Update-DR the staged bits are copied to the key output, which feeds an on-chip decryptor. The copy happens only if exactly 512 bits were shifted and the validity flag is clear.

The validity flag marks the stored key as usable. It is set by a successful load and is cleared only by holding the clear-validity instruction in Run-Test/Idle for a minimum number of TCK cycles, or by an erase request. Because a load needs the flag to be clear, a valid key cannot be overwritten without first going through the timed clear. While the key-load instruction is selected, the block takes the TDO path and drives it with a constant 0, so no key bit ever reaches the pin.

Top module: `vkey_chain`

## Requirements
- R1: After power-on reset (rstN low), key is all zeros and keyValid is 0.
- R2: While instr equals the key-load code 10'b01_1010_1101 (0x1AD) and shiftDr is 1, each rising tck edge shifts tdi into the staging chain, least significant bit first. The first bit shifted ends in key[0] and the 512th in key[511].
- R3: On the rising tck edge with updateDr 1 under the key-load code, if exactly 512 shifts happened since the code was selected or since the last Update-DR, and keyValid is 0, the staged value appears on key and keyValid becomes 1 after that same edge.
- R4: An Update-DR after a shift count other than 512 (for example 511 or 513) leaves keyValid at 0 and key unchanged.
- R5: While keyValid is 1, a complete 512-bit load attempt leaves key unchanged.
- R6: keyValid clears after the 10th consecutive rising tck edge at which instr equals the clear-validity code 10'b00_0010_1001 (0x029) and inIdle is 1. After 9 such edges it is still 1.
- R7: The clear-validity cycle count restarts from zero on any edge where instr differs from the clear code or inIdle is 0.
- R8: Clearing validity does not change the key output.
- R9: An edge with eraseReq at 1 zeroes key and clears keyValid.
- R10: tdoEn is 1 exactly when instr equals the key-load code, and tdoOut is always 0.
- R11: Shift and update activity under any instruction other than the key-load code does not load the key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| instr | input | 10 | Current instruction from the TAP instruction register |
| shiftDr | input | 1 | TAP is in Shift-DR |
| updateDr | input | 1 | TAP is in Update-DR |
| inIdle | input | 1 | TAP is in Run-Test/Idle |
| tdi | input | 1 | Serial test data in |
| eraseReq | input | 1 | Request to erase the key and validity |
| key | output | 512 | Stored key for the decryptor |
| keyValid | output | 1 | Stored key is valid |
| tdoEn | output | 1 | Block owns the TDO path |
| tdoOut | output | 1 | TDO bit contributed by the block |

## Verification
The assertions assume that the TAP controller never raises shiftDr, updateDr and inIdle together, since they stand for distinct TAP states. They also assume the instruction changes only between those states, as an instruction register does. The bench keeps to this by asserting at most one state indication per cycle and by changing instr only while shiftDr and updateDr are low. The timed clear is then exercised by breaking the Run-Test/Idle stay or switching the instruction for one cycle.

// File: rtl/vkey_pkg.sv
package vkey_pkg;

  typedef struct packed {
    logic shift;   // move one tdi bit into the staging chain
    logic commit;  // copy staging chain to the key
    logic wipe;    // erase staging chain and key
  } vkeyStrobe_t;

endpackage

// File: rtl/vkey_ctrl.sv
module vkey_ctrl
  import vkey_pkg::*;
#(
  parameter int KEY_BITS = 512,
  parameter int IR_BITS = 10,
  parameter logic [IR_BITS-1:0] LOAD_CODE = 10'b01_1010_1101,
  parameter logic [IR_BITS-1:0] CLEAR_CODE = 10'b00_0010_1001,
  parameter int CLEAR_MIN = 10
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic [IR_BITS-1:0] instr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               inIdle,
  input  logic               eraseReq,
  output vkeyStrobe_t        strobe,
  output logic               keyValid,
  output logic               tdoEn
);

  localparam int CNT_W = $clog2(KEY_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(KEY_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(KEY_BITS + 1);
  localparam int CLR_W = $clog2(CLEAR_MIN + 1);
  localparam logic [CLR_W-1:0] CLR_LAST = CLR_W'(CLEAR_MIN - 1);
  localparam logic [CLR_W-1:0] CLR_SAT = CLR_W'(CLEAR_MIN);

  logic isLoad;
  logic isClear;
  logic clearActive;
  logic clearHit;
  logic [CNT_W-1:0] shiftCnt;
  logic [CLR_W-1:0] clearCnt;

  assign isLoad = (instr == LOAD_CODE);
  assign isClear = (instr == CLEAR_CODE);
  assign clearActive = isClear && inIdle;
  assign clearHit = clearActive && (clearCnt == CLR_LAST);

  always_comb begin
    strobe.shift = isLoad && shiftDr;
    strobe.commit = isLoad && updateDr && (shiftCnt == CNT_FULL) && !keyValid;
    strobe.wipe = eraseReq;
  end

  assign tdoEn = isLoad;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      shiftCnt <= '0;
      clearCnt <= '0;
      keyValid <= 1'b0;
    end else if (eraseReq) begin
      shiftCnt <= '0;
      clearCnt <= '0;
      keyValid <= 1'b0;
    end else begin
      if (!isLoad || updateDr) begin
        shiftCnt <= '0;
      end else if (shiftDr && (shiftCnt != CNT_SAT)) begin
        shiftCnt <= shiftCnt + 1'b1;
      end

      if (!clearActive) begin
        clearCnt <= '0;
      end else if (clearCnt != CLR_SAT) begin
        clearCnt <= clearCnt + 1'b1;
      end

      if (strobe.commit) begin
        keyValid <= 1'b1;
      end else if (clearHit) begin
        keyValid <= 1'b0;
      end
    end
  end

  // R3: validity only rises right after a full-length update under the load code
  assert_valid_rise_R3: assert property (@(posedge tck) disable iff (!rstN)
    (keyValid && !$past(keyValid)) |-> $past(isLoad && updateDr && shiftCnt == CNT_FULL));

  // R6: validity only falls after the timed clear or an erase
  assert_valid_fall_R6: assert property (@(posedge tck) disable iff (!rstN)
    (!keyValid && $past(keyValid)) |-> ($past(eraseReq) || $past(clearActive && clearCnt == CLR_LAST)));

  // R7: leaving the clear condition restarts the count
  assert_clear_restart_R7: assert property (@(posedge tck) disable iff (!rstN)
    $past(!clearActive) |-> (clearCnt == '0));

  // R7: the clear count never passes its saturation value
  assert_clear_bound_R7: assert property (@(posedge tck) disable iff (!rstN)
    clearCnt <= CLR_SAT);

endmodule

// File: rtl/vkey_datapath.sv
module vkey_datapath
  import vkey_pkg::*;
#(
  parameter int KEY_BITS = 512
) (
  input  logic                tck,
  input  logic                rstN,
  input  vkeyStrobe_t         strobe,
  input  logic                tdi,
  input  logic                keyValid,
  output logic [KEY_BITS-1:0] key
);

  logic [KEY_BITS-1:0] stage;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
      key <= '0;
    end else if (strobe.wipe) begin
      stage <= '0;
      key <= '0;
    end else begin
      if (strobe.shift) begin
        stage <= {tdi, stage[KEY_BITS-1:1]};
      end
      if (strobe.commit) begin
        key <= stage;
      end
    end
  end

  // R5: a key held valid across an edge does not change
  assert_key_hold_R5: assert property (@(posedge tck) disable iff (!rstN)
    ($past(keyValid) && keyValid) |-> $stable(key));

  // R3: the key only changes on a commit or a wipe
  assert_key_write_R3: assert property (@(posedge tck) disable iff (!rstN)
    !$stable(key) |-> $past(strobe.commit || strobe.wipe));

  // R9: an erase leaves an all-zero key
  assert_wipe_zero_R9: assert property (@(posedge tck) disable iff (!rstN)
    $past(strobe.wipe) |-> (key == '0));

endmodule

// File: rtl/vkey_chain.sv
module vkey_chain
  import vkey_pkg::*;
#(
  parameter int KEY_BITS = 512,
  parameter int IR_BITS = 10,
  parameter logic [IR_BITS-1:0] LOAD_CODE = 10'b01_1010_1101,
  parameter logic [IR_BITS-1:0] CLEAR_CODE = 10'b00_0010_1001,
  parameter int CLEAR_MIN = 10
) (
  input  logic                tck,
  input  logic                rstN,
  input  logic [IR_BITS-1:0]  instr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                inIdle,
  input  logic                tdi,
  input  logic                eraseReq,
  output logic [KEY_BITS-1:0] key,
  output logic                keyValid,
  output logic                tdoEn,
  output logic                tdoOut
);

  vkeyStrobe_t strobe;

  vkey_ctrl #(
    .KEY_BITS(KEY_BITS),
    .IR_BITS(IR_BITS),
    .LOAD_CODE(LOAD_CODE),
    .CLEAR_CODE(CLEAR_CODE),
    .CLEAR_MIN(CLEAR_MIN)
  ) uCtrl (
    .tck(tck),
    .rstN(rstN),
    .instr(instr),
    .shiftDr(shiftDr),
    .updateDr(updateDr),
    .inIdle(inIdle),
    .eraseReq(eraseReq),
    .strobe(strobe),
    .keyValid(keyValid),
    .tdoEn(tdoEn)
  );

  vkey_datapath #(
    .KEY_BITS(KEY_BITS)
  ) uData (
    .tck(tck),
    .rstN(rstN),
    .strobe(strobe),
    .tdi(tdi),
    .keyValid(keyValid),
    .key(key)
  );

  // R10: the chain end is never routed out; the TDO contribution is fixed low
  assign tdoOut = 1'b0;

endmodule

// File: tb/sim_vkey_chain.sv
`timescale 1ns/1ps
module sim_vkey_chain;

  localparam logic [9:0] LOAD = 10'h1AD;
  localparam logic [9:0] CLR = 10'h029;
  localparam logic [9:0] OTHER = 10'h006;

  // clear-validity vectors: preHold, breakKind (0 none, 1 leave idle, 2 switch instr), postHold, expected keyValid
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{9, 0, 0, 1},
    '{10, 0, 0, 0},
    '{6, 1, 6, 1},
    '{14, 0, 0, 0},
    '{6, 2, 9, 1},
    '{6, 1, 10, 0}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [9:0] instr;
  logic shiftDr, updateDr, inIdle, tdi, eraseReq;
  logic [511:0] key;
  logic keyValid, tdoEn, tdoOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [511:0] curKey;

  always #2.5 clk = ~clk;

  vkey_chain u0 (
    .tck(clk), .rstN(rstN), .instr(instr), .shiftDr(shiftDr),
    .updateDr(updateDr), .inIdle(inIdle), .tdi(tdi), .eraseReq(eraseReq),
    .key(key), .keyValid(keyValid), .tdoEn(tdoEn), .tdoOut(tdoOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkKey(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] mkKey(input int seed);
    logic [511:0] k;
    for (int i = 0; i < 16; i++) begin
      k[i*32 +: 32] = (32'(seed) * 32'h9E3779B9) ^ (32'(i) * 32'h01010101) ^ 32'h5A5A0001;
    end
    return k;
  endfunction

  // shift n bits of k (LSB first, zeros past bit 511) under code, then one Update-DR
  task automatic loadKey(input logic [9:0] code, input logic [511:0] k, input int n);
    instr = code;
    inIdle = 1'b0;
    tick();
    for (int i = 0; i < n; i++) begin
      shiftDr = 1'b1;
      tdi = (i < 512) ? k[i] : 1'b0;
      tick();
    end
    shiftDr = 1'b0;
    tdi = 1'b0;
    updateDr = 1'b1;
    tick();
    updateDr = 1'b0;
    instr = OTHER;
    tick();
  endtask

  initial begin
    rstN = 1'b0;
    instr = OTHER;
    shiftDr = 1'b0;
    updateDr = 1'b0;
    inIdle = 1'b0;
    tdi = 1'b0;
    eraseReq = 1'b0;
    @(negedge clk);
    tick();
    checkKey("R1 key after reset", key, '0);
    checkBit("R1 valid after reset", keyValid, 1'b0);
    rstN = 1'b1;
    tick();

    // R10: TDO ownership and value
    instr = LOAD;
    shiftDr = 1'b1;
    tdi = 1'b1;
    tick();
    checkBit("R10 tdoEn under load code", tdoEn, 1'b1);
    checkBit("R10 tdoOut under load code", tdoOut, 1'b0);
    shiftDr = 1'b0;
    instr = OTHER;
    tick();
    checkBit("R10 tdoEn under other code", tdoEn, 1'b0);

    // R2, R3: full load
    curKey = mkKey(1);
    loadKey(LOAD, curKey, 512);
    checkKey("R2 R3 key after full load", key, curKey);
    checkBit("R3 valid after full load", keyValid, 1'b1);

    // R5: second load while valid
    loadKey(LOAD, mkKey(2), 512);
    checkKey("R5 key kept while valid", key, curKey);

    // R6, R7, R8: timed clear vectors
    for (int v = 0; v < NVEC; v++) begin
      if (keyValid !== 1'b1) begin
        curKey = mkKey(10 + v);
        loadKey(LOAD, curKey, 512);
      end
      instr = CLR;
      inIdle = 1'b1;
      for (int c = 0; c < VEC[v][0]; c++) tick();
      if (VEC[v][1] == 1) begin
        inIdle = 1'b0;
        tick();
        inIdle = 1'b1;
      end else if (VEC[v][1] == 2) begin
        instr = OTHER;
        tick();
        instr = CLR;
      end
      for (int c = 0; c < VEC[v][2]; c++) tick();
      instr = OTHER;
      inIdle = 1'b0;
      tick();
      checkBit($sformatf("R6 R7 valid after clear vector %0d", v), keyValid, VEC[v][3] != 0);
      checkKey($sformatf("R8 key after clear vector %0d", v), key, curKey);
    end

    // R4: wrong shift counts
    loadKey(LOAD, mkKey(20), 511);
    checkBit("R4 valid after 511 shifts", keyValid, 1'b0);
    checkKey("R4 key after 511 shifts", key, curKey);
    loadKey(LOAD, mkKey(21), 513);
    checkBit("R4 valid after 513 shifts", keyValid, 1'b0);
    checkKey("R4 key after 513 shifts", key, curKey);

    // R11: shifting under another instruction
    loadKey(OTHER, mkKey(22), 512);
    checkBit("R11 valid after other-code shift", keyValid, 1'b0);
    checkKey("R11 key after other-code shift", key, curKey);

    // R3: fresh load after clear
    curKey = mkKey(23);
    loadKey(LOAD, curKey, 512);
    checkKey("R3 key after reload", key, curKey);
    checkBit("R3 valid after reload", keyValid, 1'b1);

    // R9: erase
    eraseReq = 1'b1;
    tick();
    eraseReq = 1'b0;
    checkKey("R9 key after erase", key, '0);
    checkBit("R9 valid after erase", keyValid, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule